// File: doc/BRIEF.md
# Configurable Reset Delay Generator

This block is the digital core of one supervisor reset channel. It watches three reset sources: a flag that says the monitored voltage is below its threshold, an active-low manual reset input, and a power-good flag. While any of them is active, the reset output is held asserted and the release timer is cleared. Once all three clear, the timer counts a one-per-millisecond tick. The output is released when the count reaches the delay chosen by the mode input.

The delay is picked by a two-bit mode. One setting gives a long fixed delay, another a short fixed delay, and a third uses a programmed count that is clamped into its legal window. The reset is driven in both polarities from registers, so neither output can glitch. Any source that becomes active again during the delay restarts timing from zero.

Top module: `rst_delay_gen`

## Requirements
- R1: After synchronous reset `rst` the block drives `rst_o` = 1 and `rst_n_o` = 0.
- R2: `sense_low` = 1 makes `rst_o` 1 at the next clock edge.
- R3: `mr_n` = 0 makes `rst_o` 1 at the next clock edge.
- R4: `pwr_good` = 0 makes `rst_o` 1 at the next clock edge.
- R5: The timer is held at zero while any source is active. A source that returns during the delay makes the channel wait a full delay again.
- R6: Mode 2'b00 (short fixed) releases `rst_o` at the clock edge after the SHORT_MS-th tick counted with all sources clear.
- R7: Mode 2'b01 and mode 2'b11 (long fixed) release after LONG_MS ticks.
- R8: Mode 2'b10 (programmable) releases after `prog_ms` ticks when PROG_MIN_MS <= `prog_ms` <= PROG_MAX_MS.
- R9: In mode 2'b10, a `prog_ms` below PROG_MIN_MS acts as PROG_MIN_MS and one above PROG_MAX_MS acts as PROG_MAX_MS.
- R10: `rst_n_o` is always the inverse of `rst_o`.
- R11: Only cycles with `ms_tick` = 1 advance the delay. With no ticks, `rst_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_low | input | 1 | Monitored voltage below threshold |
| mr_n | input | 1 | Manual reset, active low |
| pwr_good | input | 1 | Supply present |
| mode | input | 2 | Delay mode: 00 short, 01/11 long, 10 programmable |
| prog_ms | input | PROG_W | Programmed delay in ticks |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low |

## Verification
On every cycle, the assertions check several things. Each source asserts the output one edge later, the timer is zero after any cycle with a source active, and the two outputs stay complementary. A release only follows a cycle in which every source was clear, and the programmed target never leaves its window. The delay lengths themselves need the bench's scenarios, and so do the mode sweep, the clamp at both ends, the restart on a mid-delay glitch and the absence of release without ticks. The bench counts ticks and checks the output one tick before and at the expected release.

// File: rtl/rst_delay_pkg.sv
package rst_delay_pkg;

    typedef enum logic [1:0] {
        DLY_SHORT    = 2'b00,
        DLY_LONG     = 2'b01,
        DLY_PROG     = 2'b10,
        DLY_LONG_ALT = 2'b11
    } dly_mode_e;

    typedef struct packed {
        logic under_volt;
        logic manual;
        logic supply_lost;
    } src_vec_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/rst_src_merge.sv
module rst_src_merge
    import rst_delay_pkg::*;
(
    input  logic     sense_low,
    input  logic     mr_n,
    input  logic     pwr_good,
    output src_vec_t srcs,
    output logic     any_active
);
    always_comb begin
        srcs.under_volt  = sense_low;
        srcs.manual      = ~mr_n;
        srcs.supply_lost = ~pwr_good;
        any_active       = |srcs;
    end
endmodule

// File: rtl/rst_delay_sel.sv
module rst_delay_sel
    import rst_delay_pkg::*;
#(
    parameter int unsigned LONG_MS     = 300,
    parameter int unsigned SHORT_MS    = 20,
    parameter int unsigned PROG_MIN_MS = 2,
    parameter int unsigned PROG_MAX_MS = 10000,
    parameter int unsigned PROG_W      = 14,
    parameter int unsigned CNT_W       = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic [PROG_W-1:0] prog_ms,
    output logic [CNT_W-1:0]  target
);
    localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(LONG_MS);
    localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(SHORT_MS);
    localparam logic [CNT_W-1:0] T_MIN   = CNT_W'(PROG_MIN_MS);
    localparam logic [CNT_W-1:0] T_MAX   = CNT_W'(PROG_MAX_MS);

    logic [31:0]      prog_wide;
    logic [CNT_W-1:0] prog_clamped;

    always_comb begin
        prog_wide = 32'(prog_ms);
        if (prog_wide < PROG_MIN_MS)
            prog_clamped = T_MIN;
        else if (prog_wide > PROG_MAX_MS)
            prog_clamped = T_MAX;
        else
            prog_clamped = prog_wide[CNT_W-1:0];
    end

    always_comb begin
        unique case (dly_mode_e'(mode))
            DLY_SHORT:    target = T_SHORT;
            DLY_LONG:     target = T_LONG;
            DLY_PROG:     target = prog_clamped;
            DLY_LONG_ALT: target = T_LONG;
            default:      target = T_LONG;
        endcase
    end

    assert_prog_window_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == DLY_PROG) |-> (target >= T_MIN && target <= T_MAX));

    assert_fixed_long_R7: assert property (@(posedge clk) disable iff (rst)
        (mode[0] == 1'b1) |-> (target == T_LONG));
endmodule

// File: rtl/rst_delay_timer.sv
module rst_delay_timer #(
    parameter int unsigned CNT_W = 14,
    parameter int unsigned CNT_CAP = 10000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (tick && (cnt < target))
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= target);

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) <= CNT_CAP);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(cnt));
endmodule

// File: rtl/rst_delay_gen.sv
module rst_delay_gen
    import rst_delay_pkg::*;
#(
    parameter int unsigned LONG_MS     = 300,
    parameter int unsigned SHORT_MS    = 20,
    parameter int unsigned PROG_MIN_MS = 2,
    parameter int unsigned PROG_MAX_MS = 10000,
    parameter int unsigned PROG_W      = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sense_low,
    input  logic              mr_n,
    input  logic              pwr_good,
    input  logic [1:0]        mode,
    input  logic [PROG_W-1:0] prog_ms,
    input  logic              ms_tick,
    output logic              rst_o,
    output logic              rst_n_o
);
    localparam int unsigned TOP_MS = max2(max2(LONG_MS, SHORT_MS), PROG_MAX_MS);
    localparam int unsigned CNT_W  = bits_for(TOP_MS);

    src_vec_t         srcs;
    logic             any_active;
    logic [CNT_W-1:0] target;
    logic             expired;

    rst_src_merge u_merge (
        .sense_low  (sense_low),
        .mr_n       (mr_n),
        .pwr_good   (pwr_good),
        .srcs       (srcs),
        .any_active (any_active)
    );

    rst_delay_sel #(
        .LONG_MS     (LONG_MS),
        .SHORT_MS    (SHORT_MS),
        .PROG_MIN_MS (PROG_MIN_MS),
        .PROG_MAX_MS (PROG_MAX_MS),
        .PROG_W      (PROG_W),
        .CNT_W       (CNT_W)
    ) u_sel (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .prog_ms (prog_ms),
        .target  (target)
    );

    rst_delay_timer #(
        .CNT_W   (CNT_W),
        .CNT_CAP (TOP_MS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (any_active),
        .tick    (ms_tick),
        .target  (target),
        .expired (expired)
    );

    logic hold;
    assign hold = any_active | ~expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_o   <= 1'b1;
            rst_n_o <= 1'b0;
        end else begin
            rst_o   <= hold;
            rst_n_o <= ~hold;
        end
    end

    assert_sense_R2: assert property (@(posedge clk) disable iff (rst)
        srcs.under_volt |=> rst_o);

    assert_manual_R3: assert property (@(posedge clk) disable iff (rst)
        srcs.manual |=> rst_o);

    assert_supply_R4: assert property (@(posedge clk) disable iff (rst)
        srcs.supply_lost |=> rst_o);

    assert_release_clean_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_o) |-> $past(!any_active));

    assert_polarity_R10: assert property (@(posedge clk) disable iff (rst)
        rst_n_o == ~rst_o);
endmodule

// File: tb/tb_rst_delay_gen.sv
module tb_rst_delay_gen;
    localparam int unsigned LONG   = 12;
    localparam int unsigned SHORT  = 5;
    localparam int unsigned PMIN   = 2;
    localparam int unsigned PMAX   = 9;
    localparam int unsigned PW     = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sense_low = 1'b0;
    logic          mr_n = 1'b0;
    logic          pwr_good = 1'b1;
    logic [1:0]    mode = 2'b00;
    logic [PW-1:0] prog_ms = '0;
    logic          ms_tick = 1'b0;
    logic          rst_o;
    logic          rst_n_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rst_delay_gen #(
        .LONG_MS     (LONG),
        .SHORT_MS    (SHORT),
        .PROG_MIN_MS (PMIN),
        .PROG_MAX_MS (PMAX),
        .PROG_W      (PW)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .sense_low (sense_low),
        .mr_n      (mr_n),
        .pwr_good  (pwr_good),
        .mode      (mode),
        .prog_ms   (prog_ms),
        .ms_tick   (ms_tick),
        .rst_o     (rst_o),
        .rst_n_o   (rst_n_o)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tick();
        ms_tick = 1'b1; cyc();
        ms_tick = 1'b0; cyc();
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_out(input string tag, input logic exp);
        check(tag, rst_o, exp);
        check({tag, " R10"}, rst_n_o, ~exp);
    endtask

    // hold manual reset, clear it, then expect release after exactly n ticks
    task automatic release_after(input string tag, input int n);
        mr_n = 1'b0; cyc(); cyc();
        check_out({tag, " held"}, 1'b1);
        mr_n = 1'b1;
        for (int i = 0; i < n - 1; i++) tick();
        check_out({tag, " one tick early"}, 1'b1);
        tick();
        check_out({tag, " released"}, 1'b0);
    endtask

    function automatic int clamp_ref(input int p);
        if (p < PMIN) return PMIN;
        if (p > PMAX) return PMAX;
        return p;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(); cyc();
        check_out("R1 reset state", 1'b1);
        rst = 1'b0;
        cyc();

        // R6 short mode
        mode = 2'b00;
        release_after("R6 short", SHORT);

        // R7 long modes
        mode = 2'b01;
        release_after("R7 long 01", LONG);
        mode = 2'b11;
        release_after("R7 long 11", LONG);

        // R8 / R9 programmable sweep over every code
        mode = 2'b10;
        for (int p = 0; p < (1 << PW); p++) begin
            prog_ms = PW'(p);
            if (p >= PMIN && p <= PMAX)
                release_after("R8 prog", clamp_ref(p));
            else
                release_after("R9 clamp", clamp_ref(p));
        end

        // R2, R3, R4 each source asserts one edge later
        mode = 2'b00;
        sense_low = 1'b1; cyc();
        check_out("R2 sense asserts", 1'b1);
        sense_low = 1'b0;
        for (int i = 0; i < SHORT; i++) tick();
        check_out("R2 release after sense", 1'b0);

        mr_n = 1'b0; cyc();
        check_out("R3 manual asserts", 1'b1);
        mr_n = 1'b1;
        for (int i = 0; i < SHORT; i++) tick();
        check_out("R3 release after manual", 1'b0);

        pwr_good = 1'b0; cyc();
        check_out("R4 supply asserts", 1'b1);
        pwr_good = 1'b1;
        for (int i = 0; i < SHORT; i++) tick();
        check_out("R4 release after supply", 1'b0);

        // R5 source glitch mid-delay restarts the full delay
        mr_n = 1'b0; cyc();
        mr_n = 1'b1;
        for (int i = 0; i < SHORT - 1; i++) tick();
        sense_low = 1'b1; ms_tick = 1'b1; cyc();
        sense_low = 1'b0; ms_tick = 1'b0; cyc();
        check_out("R5 glitch holds", 1'b1);
        for (int i = 0; i < SHORT - 1; i++) tick();
        check_out("R5 restarted not early", 1'b1);
        tick();
        check_out("R5 restarted full delay", 1'b0);

        // R5 ticks during an active source are not counted
        pwr_good = 1'b0;
        for (int i = 0; i < SHORT + 3; i++) tick();
        pwr_good = 1'b1;
        cyc();
        check_out("R5 ticks ignored while active", 1'b1);
        for (int i = 0; i < SHORT - 1; i++) tick();
        check_out("R5 counted from zero", 1'b1);
        tick();
        check_out("R5 release after clear", 1'b0);

        // R11 no ticks, no release
        mr_n = 1'b0; cyc();
        mr_n = 1'b1;
        for (int i = 0; i < 50; i++) cyc();
        check_out("R11 no tick stays asserted", 1'b1);
        for (int i = 0; i < SHORT; i++) tick();
        check_out("R11 ticks then release", 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule